// File: doc/BRIEF.md
# MAC Address Lookup Table Engine

This block keeps a table of destination MAC address entries for a small three-port Ethernet switch and answers lookups against it. Each entry is a 72-bit record seen by software as three 32-bit data words. Software stages those words in the block's register set and moves a whole entry into or out of the table by writing an index to a table-access register. A strobe bit in that register selects a write; without the strobe the access is a read.

A lookup request carries a 48-bit destination MAC. The engine walks the table from index 0 upward and stops at the first valid address entry whose MAC is equal. It returns a hit flag, the multicast indication stored in the entry and the set of egress ports. A hit whose ports are all blocked is reported as a drop. A control register turns the engine on and starts a self-clearing wipe of the whole table. Three per-port control registers give each port a forwarding state.

Table contents are undefined after reset. Software clears the table once before it enables lookups.

Top module: `addr_tbl_engine`

## Requirements
- R1: After reset, every register (control, table access, the three data words, the three port states) reads 0, and the lookup outputs (`lkp_busy`, `lkp_done`, `lkp_hit`, `lkp_mcast`, `lkp_ports`, `lkp_drop`) are 0.
- R2: Register offsets are 0 control, 1 table access, 2/3/4 data words 0/1/2, and 5/6/7 port states 0/1/2. `reg_rdata` shows the register selected by `reg_addr` one clock later.
- R3: Writing the table-access register with bit 31 set stores {word2[7:0], word1, word0} at the index in bits 9:0. Writing it with bit 31 clear loads that entry back into the data words, and word2 bits 31:8 read back as 0.
- R4: An entry matches when its type field, word1 bits 29:28, equals 1 and its MAC equals the request. The MAC is laid out as byte 0 in word1 bits 15:8, byte 1 in word1 bits 7:0 and bytes 2..5 in word0 bits 31:24 down to 7:0. Any other type value never matches.
- R5: When several entries match, the one with the lowest index is returned.
- R6: `lkp_mcast` reports word1 bit 8 of the matching entry. For a unicast entry, word2 bits 3:2 hold a port number and the port mask is one-hot of that number; the value 3 gives an empty mask. For a multicast entry, word2 bits 4:2 hold the port map, and it is used only when word1 bits 31:30 equal 3; otherwise the mask is empty.
- R7: A port forwards only when bits 1:0 of its port-state register equal 3. `lkp_ports` is the entry's mask ANDed with the forwarding ports. A hit with an empty result raises `lkp_drop`.
- R8: Control bit 31 enables lookups. While it is 0, every lookup completes as a miss.
- R9: Writing control bit 30 as 1 zeroes every entry, one per clock. Bit 30 reads 1 until the clear has finished. A lookup in flight or requested during the clear completes as a miss. Table reads and writes issued during the clear are ignored.
- R10: An accepted lookup raises `lkp_done` at most DEPTH+2 clocks after the request. A request while `lkp_busy` is high is ignored.
- R11: `lkp_done` is a one-clock pulse. `lkp_hit`, `lkp_mcast`, `lkp_ports` and `lkp_drop` are 0 whenever `lkp_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| lkp_req | input | 1 | Start a lookup (taken when not busy) |
| lkp_mac | input | 48 | Destination MAC to look up |
| lkp_busy | output | 1 | A scan is in progress |
| lkp_done | output | 1 | One-clock result strobe |
| lkp_hit | output | 1 | A matching entry was found |
| lkp_mcast | output | 1 | Matching entry is multicast |
| lkp_ports | output | 3 | Forwarding ports for the frame |
| lkp_drop | output | 1 | Hit, but no port may forward |

## Verification
The case where two functions meet is a table clear commanded while a scan is still walking the table. The bench starts a lookup for an address stored in the very last entry, so the scan runs long. A few hundred clocks into that scan it writes the clear bit. The result is judged correct when the in-flight lookup ends early as a miss, inside the DEPTH+2 bound. The clear must also finish normally, and afterwards the formerly present entries are gone and a table write issued during the clear has left no trace.

// File: rtl/addr_tbl_pkg.sv
package addr_tbl_pkg;
  localparam int NUM_PORTS = 3;

  // register offsets
  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_TBL   = 3'd1;
  localparam logic [2:0] OFS_W0    = 3'd2;
  localparam logic [2:0] OFS_W1    = 3'd3;
  localparam logic [2:0] OFS_W2    = 3'd4;
  localparam logic [2:0] OFS_PORT0 = 3'd5;

  // control / table-access bits
  localparam int BIT_EN     = 31;
  localparam int BIT_CLR    = 30;
  localparam int BIT_STROBE = 31;

  // entry field positions
  localparam int TYPE_LO   = 60;
  localparam int FWD_LO    = 62;
  localparam int MASK_LO   = 66;
  localparam int MCAST_BIT = 40;

  localparam logic [1:0] TYPE_ADDR = 2'd1;
  localparam logic [1:0] STATE_FWD = 2'd3;

  typedef enum logic {SC_IDLE, SC_SCAN} scan_state_t;
endpackage

// File: rtl/addr_tbl_mem.sv
module addr_tbl_mem #(
  parameter int DEPTH = 1024,
  parameter int W     = 72,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_rdata
);
  logic [W-1:0] mem [DEPTH];

  // port A: read/write (software, clear); port B: read-only (scan)
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/addr_tbl_regs.sv
module addr_tbl_regs
  import addr_tbl_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int ENTRY_W = 72,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int EXT_W  = ENTRY_W - 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 mem_we,
  output logic [IDX_W-1:0]     mem_addr,
  output logic [ENTRY_W-1:0]   mem_wdata,
  input  logic [ENTRY_W-1:0]   mem_rdata,
  output logic                 eng_en,
  output logic                 clearing,
  output logic [NUM_PORTS-1:0] fwd_mask
);
  logic [31:0]      w0_q, w1_q, w2_q;
  logic [IDX_W-1:0] tbl_idx_q;
  logic [IDX_W-1:0] clr_idx;
  logic             rd_pend;
  logic [1:0]       pstate_q [NUM_PORTS];
  logic [31:0]      rd_mux;
  logic             tbl_acc;

  assign tbl_acc  = reg_we && (reg_addr == OFS_TBL) && !clearing;
  assign mem_we   = clearing || (tbl_acc && reg_wdata[BIT_STROBE]);
  assign mem_addr = clearing ? clr_idx : reg_wdata[IDX_W-1:0];
  assign mem_wdata = clearing ? '0 : {w2_q[EXT_W-1:0], w1_q, w0_q};

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PORTS; gp++) begin : g_fwd
      assign fwd_mask[gp] = (pstate_q[gp] == STATE_FWD);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_en    <= 1'b0;
      clearing  <= 1'b0;
      clr_idx   <= '0;
      rd_pend   <= 1'b0;
      tbl_idx_q <= '0;
      w0_q      <= '0;
      w1_q      <= '0;
      w2_q      <= '0;
      for (int p = 0; p < NUM_PORTS; p++) pstate_q[p] <= 2'd0;
    end else begin
      rd_pend <= tbl_acc && !reg_wdata[BIT_STROBE];
      if (reg_we && reg_addr == OFS_CTRL) begin
        eng_en <= reg_wdata[BIT_EN];
        if (reg_wdata[BIT_CLR] && !clearing) begin
          clearing <= 1'b1;
          clr_idx  <= '0;
        end
      end
      if (clearing) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == IDX_W'(DEPTH - 1)) clearing <= 1'b0;
      end
      if (tbl_acc) tbl_idx_q <= reg_wdata[IDX_W-1:0];
      if (reg_we && reg_addr == OFS_W0) w0_q <= reg_wdata;
      if (reg_we && reg_addr == OFS_W1) w1_q <= reg_wdata;
      if (reg_we && reg_addr == OFS_W2) w2_q <= reg_wdata;
      if (rd_pend) begin
        w0_q <= mem_rdata[31:0];
        w1_q <= mem_rdata[63:32];
        w2_q <= 32'(mem_rdata[ENTRY_W-1:64]);
      end
      for (int p = 0; p < NUM_PORTS; p++)
        if (reg_we && reg_addr == OFS_PORT0 + 3'(p)) pstate_q[p] <= reg_wdata[1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_CTRL: begin
        rd_mux[BIT_EN]  = eng_en;
        rd_mux[BIT_CLR] = clearing;
      end
      OFS_TBL: rd_mux = 32'(tbl_idx_q);
      OFS_W0:  rd_mux = w0_q;
      OFS_W1:  rd_mux = w1_q;
      OFS_W2:  rd_mux = w2_q;
      default: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (reg_addr == OFS_PORT0 + 3'(p)) rd_mux = 32'(pstate_q[p]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  AST_CLEAR_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(clearing) |-> $past(clr_idx) == IDX_W'(DEPTH - 1)); // R9
  AST_NO_READ_DURING_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(clearing) |-> !rd_pend); // R9
endmodule

// File: rtl/addr_tbl_scan.sv
module addr_tbl_scan
  import addr_tbl_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int ENTRY_W = 72,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 eng_en,
  input  logic                 clearing,
  input  logic [NUM_PORTS-1:0] fwd_mask,
  input  logic                 lkp_req,
  input  logic [47:0]          lkp_mac,
  output logic                 lkp_busy,
  output logic                 lkp_done,
  output logic                 lkp_hit,
  output logic                 lkp_mcast,
  output logic [NUM_PORTS-1:0] lkp_ports,
  output logic                 lkp_drop,
  output logic [IDX_W-1:0]     rd_addr,
  input  logic [ENTRY_W-1:0]   rd_data
);
  scan_state_t          state;
  logic [47:0]          mac_q;
  logic [IDX_W-1:0]     rd_idx, cmp_idx;
  logic                 pend;
  logic [CNT_W-1:0]     cnt;

  logic [1:0]           ent_type, ent_fwd, uc_port;
  logic                 ent_mc, match;
  logic [NUM_PORTS-1:0] mc_map, ent_mask, out_mask;

  assign rd_addr  = rd_idx;
  assign lkp_busy = (state == SC_SCAN);

  always_comb begin
    ent_type = rd_data[TYPE_LO+1:TYPE_LO];
    ent_fwd  = rd_data[FWD_LO+1:FWD_LO];
    uc_port  = rd_data[MASK_LO+1:MASK_LO];
    mc_map   = rd_data[MASK_LO+NUM_PORTS-1:MASK_LO];
    ent_mc   = rd_data[MCAST_BIT];
    match    = pend && (ent_type == TYPE_ADDR) && (rd_data[47:0] == mac_q);
    if (ent_mc)
      ent_mask = (ent_fwd == STATE_FWD) ? mc_map : '0;
    else
      ent_mask = (int'(uc_port) < NUM_PORTS) ? (NUM_PORTS'(1) << uc_port) : '0;
    out_mask = ent_mask & fwd_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SC_IDLE;
      mac_q     <= '0;
      rd_idx    <= '0;
      cmp_idx   <= '0;
      pend      <= 1'b0;
      cnt       <= '0;
      lkp_done  <= 1'b0;
      lkp_hit   <= 1'b0;
      lkp_mcast <= 1'b0;
      lkp_ports <= '0;
      lkp_drop  <= 1'b0;
    end else begin
      lkp_done  <= 1'b0;
      lkp_hit   <= 1'b0;
      lkp_mcast <= 1'b0;
      lkp_ports <= '0;
      lkp_drop  <= 1'b0;
      case (state)
        SC_IDLE: begin
          if (lkp_req) begin
            if (!eng_en || clearing) begin
              lkp_done <= 1'b1;
            end else begin
              state  <= SC_SCAN;
              mac_q  <= lkp_mac;
              rd_idx <= '0;
              pend   <= 1'b0;
              cnt    <= '0;
            end
          end
        end
        SC_SCAN: begin
          cnt <= cnt + 1'b1;
          if (!eng_en || clearing) begin
            lkp_done <= 1'b1;
            state    <= SC_IDLE;
            pend     <= 1'b0;
          end else if (match) begin
            lkp_done  <= 1'b1;
            lkp_hit   <= 1'b1;
            lkp_mcast <= ent_mc;
            lkp_ports <= out_mask;
            lkp_drop  <= (out_mask == '0);
            state     <= SC_IDLE;
            pend      <= 1'b0;
          end else if (pend && cmp_idx == IDX_W'(DEPTH - 1)) begin
            lkp_done <= 1'b1;
            state    <= SC_IDLE;
            pend     <= 1'b0;
          end else begin
            pend    <= 1'b1;
            cmp_idx <= rd_idx;
            rd_idx  <= rd_idx + 1'b1;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    lkp_done |=> !lkp_done); // R11
  AST_QUIET_WITHOUT_DONE: assert property (@(posedge clk) disable iff (rst)
    !lkp_done |-> (!lkp_hit && !lkp_mcast && !lkp_drop && lkp_ports == '0)); // R11
  AST_DROP_IS_EMPTY_HIT: assert property (@(posedge clk) disable iff (rst)
    lkp_drop |-> (lkp_hit && lkp_ports == '0)); // R7
  AST_FWD_PORTS_ONLY: assert property (@(posedge clk) disable iff (rst)
    lkp_done |-> ((lkp_ports & ~$past(fwd_mask)) == '0)); // R7
  AST_CLEAR_MISS: assert property (@(posedge clk) disable iff (rst)
    (lkp_done && $past(clearing)) |-> !lkp_hit); // R9
  AST_DISABLED_MISS: assert property (@(posedge clk) disable iff (rst)
    (lkp_done && !$past(eng_en)) |-> !lkp_hit); // R8
  AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    (state == SC_SCAN) |-> cnt <= CNT_W'(DEPTH)); // R10
endmodule

// File: rtl/addr_tbl_engine.sv
module addr_tbl_engine
  import addr_tbl_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int ENTRY_W = 72
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lkp_req,
  input  logic [47:0] lkp_mac,
  output logic        lkp_busy,
  output logic        lkp_done,
  output logic        lkp_hit,
  output logic        lkp_mcast,
  output logic [2:0]  lkp_ports,
  output logic        lkp_drop
);
  localparam int IDX_W = $clog2(DEPTH);

  logic                 mem_we;
  logic [IDX_W-1:0]     mem_addr, scan_addr;
  logic [ENTRY_W-1:0]   mem_wdata, mem_rdata, scan_data;
  logic                 eng_en, clearing;
  logic [NUM_PORTS-1:0] fwd_mask;

  addr_tbl_regs #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .eng_en(eng_en), .clearing(clearing), .fwd_mask(fwd_mask)
  );

  addr_tbl_mem #(.DEPTH(DEPTH), .W(ENTRY_W)) u_mem (
    .clk(clk),
    .a_we(mem_we), .a_addr(mem_addr), .a_wdata(mem_wdata), .a_rdata(mem_rdata),
    .b_addr(scan_addr), .b_rdata(scan_data)
  );

  addr_tbl_scan #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_scan (
    .clk(clk), .rst(rst),
    .eng_en(eng_en), .clearing(clearing), .fwd_mask(fwd_mask),
    .lkp_req(lkp_req), .lkp_mac(lkp_mac),
    .lkp_busy(lkp_busy), .lkp_done(lkp_done), .lkp_hit(lkp_hit),
    .lkp_mcast(lkp_mcast), .lkp_ports(lkp_ports), .lkp_drop(lkp_drop),
    .rd_addr(scan_addr), .rd_data(scan_data)
  );
endmodule

// File: tb/addr_tbl_engine_bench.sv
`timescale 1ns/1ps
module addr_tbl_engine_bench;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        lkp_req;
  logic [47:0] lkp_mac;
  logic        lkp_busy, lkp_done, lkp_hit, lkp_mcast, lkp_drop;
  logic [2:0]  lkp_ports;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  addr_tbl_engine #(.DEPTH(DEPTH)) u_addr_tbl_engine (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lkp_req(lkp_req), .lkp_mac(lkp_mac),
    .lkp_busy(lkp_busy), .lkp_done(lkp_done), .lkp_hit(lkp_hit),
    .lkp_mcast(lkp_mcast), .lkp_ports(lkp_ports), .lkp_drop(lkp_drop)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // expected result encoding: {hit, mcast, ports[2:0], drop}
  localparam int NV = 7;
  localparam logic [47:0] V_MAC [NV] = '{
    48'h021122334455, 48'h01005E000001, 48'h01005E000002, 48'h02AABBCCDDEE,
    48'h020000000099, 48'h020000000077, 48'h123456789ABC };
  localparam logic [5:0] V_EXP [NV] = '{
    6'b1_0_010_0, 6'b1_1_101_0, 6'b1_1_000_1, 6'b0_0_000_0,
    6'b1_0_001_0, 6'b1_0_000_1, 6'b0_0_000_0 };
  localparam string V_REQ [NV] = '{"R5", "R6", "R6", "R4", "R4", "R6", "R4"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic write_entry(input int idx, input logic [31:0] w0, input logic [31:0] w1,
                             input logic [31:0] w2);
    reg_write(3'd2, w0);
    reg_write(3'd3, w1);
    reg_write(3'd4, w2);
    reg_write(3'd1, 32'h8000_0000 | 32'(idx));
  endtask

  task automatic read_entry(input int idx, output logic [95:0] ent);
    logic [31:0] r0, r1, r2;
    reg_write(3'd1, 32'(idx));
    @(negedge clk);
    @(negedge clk);
    reg_read(3'd2, r0);
    reg_read(3'd3, r1);
    reg_read(3'd4, r2);
    ent = {r2, r1, r0};
  endtask

  task automatic lookup(input logic [47:0] mac, output logic [5:0] res, output int cyc);
    lkp_req = 1'b1; lkp_mac = mac;
    @(negedge clk);
    lkp_req = 1'b0;
    cyc = 1;
    while (!lkp_done && cyc < 3 * DEPTH) begin
      @(negedge clk);
      cyc++;
    end
    res = {lkp_hit, lkp_mcast, lkp_ports, lkp_drop};
  endtask

  task automatic wait_clear(output int cyc);
    logic [31:0] c;
    cyc = 0;
    c = 32'h4000_0000;
    while (c[30] && cyc < 4 * DEPTH) begin
      reg_read(3'd0, c);
      cyc++;
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic [5:0]  res;
    logic [95:0] ent;
    int          cyc;

    rst = 1'b1; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    lkp_req = 1'b0; lkp_mac = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 lookup outputs", {58'd0, lkp_busy, lkp_done, lkp_hit, lkp_mcast, lkp_drop, |lkp_ports}, 64'd0);
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), rd);
      check("R1 register reset", 64'(rd), 64'd0);
    end

    // R9: initial clear, bit 30 reads 1 while running
    reg_write(3'd0, 32'h4000_0000);
    reg_read(3'd0, rd);
    check("R9 clear busy bit", 64'(rd[30]), 64'd1);
    wait_clear(cyc);
    check("R9 clear finishes", 64'(rd[30] == 1'b1 && cyc < 4 * DEPTH), 64'd1);

    // R2 enable, ports forwarding
    reg_write(3'd0, 32'h8000_0000);
    reg_write(3'd5, 32'd3);
    reg_write(3'd6, 32'd3);
    reg_write(3'd7, 32'd3);
    reg_read(3'd6, rd);
    check("R2 port state readback", 64'(rd), 64'd3);

    // program table
    write_entry(3,    32'h22334455, 32'h1000_0211, 32'h4);
    write_entry(5,    32'h22334455, 32'h1000_0211, 32'h8);
    write_entry(7,    32'h5E000001, 32'hD000_0100, 32'h14);
    write_entry(9,    32'h5E000002, 32'h5000_0100, 32'h1C);
    write_entry(11,   32'hBBCCDDEE, 32'h2000_02AA, 32'h4);
    write_entry(13,   32'h00000077, 32'h1000_0200, 32'hC);
    write_entry(1023, 32'h00000099, 32'h1000_0200, 32'h0);
    write_entry(20,   32'h01020304, 32'h0000_0506, 32'hFFFF_FFF4);

    // R3: readback through the data words
    read_entry(7, ent);
    check("R3 entry readback", 64'(ent[63:0]), 64'hD000_0100_5E00_0001);
    check("R3 word2 readback", 64'(ent[95:64]), 64'h14);
    read_entry(20, ent);
    check("R3 word2 upper bits zero", 64'(ent[95:64]), 64'hF4);
    reg_read(3'd1, rd);
    check("R2 table index readback", 64'(rd), 64'd20);

    // vector walk: R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      lookup(V_MAC[v], res, cyc);
      check(V_REQ[v], 64'(res), 64'(V_EXP[v]));
      check("R10 bound", 64'(cyc <= DEPTH + 2), 64'd1);
    end

    // R7: port 1 blocked (state 1), port 2 disabled (state 0)
    reg_write(3'd6, 32'd1);
    reg_write(3'd7, 32'd0);
    lookup(48'h021122334455, res, cyc);
    check("R7 blocked unicast drops", 64'(res), 64'(6'b1_0_000_1));
    lookup(48'h01005E000001, res, cyc);
    check("R7 multicast masked", 64'(res), 64'(6'b1_1_001_0));
    reg_write(3'd6, 32'd3);
    reg_write(3'd7, 32'd3);

    // R8: disabled engine misses
    reg_write(3'd0, 32'h0);
    lookup(48'h021122334455, res, cyc);
    check("R8 disabled miss", 64'(res), 64'd0);
    reg_write(3'd0, 32'h8000_0000);

    // R10: request while busy is ignored
    lkp_req = 1'b1; lkp_mac = 48'h020000000099;
    @(negedge clk);
    lkp_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 busy during scan", 64'(lkp_busy), 64'd1);
    lkp_req = 1'b1; lkp_mac = 48'h021122334455;
    @(negedge clk);
    lkp_req = 1'b0;
    cyc = 0;
    while (!lkp_done && cyc < 3 * DEPTH) begin
      @(negedge clk);
      cyc++;
    end
    check("R10 second request ignored", 64'({lkp_hit, lkp_mcast, lkp_ports, lkp_drop}), 64'(6'b1_0_001_0));
    @(negedge clk);
    check("R11 done is a pulse", 64'({lkp_done, lkp_hit, lkp_ports}), 64'd0);

    // R9: clear lands in the middle of a long scan
    lkp_req = 1'b1; lkp_mac = 48'h020000000099;
    @(negedge clk);
    lkp_req = 1'b0;
    cyc = 1;
    repeat (300) begin
      @(negedge clk);
      cyc++;
    end
    reg_write(3'd0, 32'hC000_0000);
    cyc++;
    while (!lkp_done && cyc < 3 * DEPTH) begin
      @(negedge clk);
      cyc++;
    end
    check("R9 scan aborted by clear", 64'({lkp_done, lkp_hit}), 64'(2'b10));
    check("R10 bound under clear", 64'(cyc <= DEPTH + 2), 64'd1);

    // R9: table write and lookup during clear ignored/miss
    write_entry(2, 32'hAABBCCDD, 32'h1000_0011, 32'h4);
    lookup(48'h0011AABBCCDD, res, cyc);
    check("R9 lookup during clear", 64'(res), 64'd0);
    wait_clear(cyc);
    read_entry(2, ent);
    check("R9 write during clear ignored", 64'(ent[63:0]), 64'd0);
    read_entry(7, ent);
    check("R9 entry wiped", 64'(ent[63:0]), 64'd0);
    lookup(48'h021122334455, res, cyc);
    check("R9 miss after clear", 64'(res), 64'd0);

    // R4: rewrite after clear, entry at index 0
    write_entry(0, 32'h22334455, 32'h1000_0211, 32'h0);
    lookup(48'h021122334455, res, cyc);
    check("R4 index 0 hit", 64'(res), 64'(6'b1_0_001_0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule